// File: doc/BRIEF.md
# Card-to-Program-Memory Boot Loader

This block fills the instruction memory of a small 18-bit-instruction processor from a removable card, with no boot software on that processor. It sits between a card block reader and the program RAM. After reset it keeps the processor in reset and waits for the reader to finish bringing the card up. It then streams one program image byte by byte and writes one instruction word for every three bytes. The processor is released only once the last word is in memory.

Several images may sit on the card, each starting on an eight-block (4096-byte) boundary. A set of switches picks one of them. Each card byte carries six bits of an instruction in its low bits, and its two upper bits are discarded. The most significant six bits of a word arrive first. The grouping into threes runs on unbroken across the 512-byte block boundaries of the card. If the reader reports a failure, loading stops for good until the next reset, the processor stays in reset and an error flag is raised.

Reader handshake: the reader holds its busy input high while it works on a request. It raises busy in the cycle after it samples a new request, which is a rising block-select or a one-cycle byte strobe. When busy is low, the error input gives the result of the last operation, and after a byte request the read data input holds the byte.

Top module: `boot_ldr`

## Requirements
- R1: While reset is active, cpu_rst is 1, and rd_block, rd_byte, mem_we and load_err are 0.
- R2: No block read is requested until the reader reports busy low after reset. If err is high at that point, load_err goes to 1 and no block is ever requested.
- R3: The image base block is BASE_BLOCK + prog_sel × 8, captured once when the reader becomes ready. Later changes of prog_sel have no effect. With the defaults, blocks base+0 to base+5 are requested in that order, and rd_addr is stable while rd_block is high.
- R4: Each written word is {b0[5:0], b1[5:0], b2[5:0]}, where b0, b1 and b2 are three consecutive card bytes with b0 first. Bits 7:6 of every byte are ignored.
- R5: Words go to addresses 0 through 1023 in increasing order, each written exactly once. The three-byte grouping carries across block boundaries, so word 170 is built from bytes 510 and 511 of the first block and byte 0 of the second.
- R6: rd_block stays high for the whole of a block and drops for at least one cycle before the next block. rd_byte is a single-cycle pulse, issued only while rd_block is high and busy is low.
- R7: cpu_rst is 1 during every memory write and falls in the cycle after the final write.
- R8: If err is seen with busy low during a block or byte read, load_err goes to 1 and stays there until reset. cpu_rst stays 1, and no further reads or memory writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_sel | input | PROG_W | Image select switches |
| rd_block | output | 1 | Block session request to the reader (rising edge starts a block) |
| rd_byte | output | 1 | Single-cycle request for the next byte |
| rd_addr | output | CARD_AW | Card block number of the requested block |
| rd_busy | input | 1 | Reader working on a request |
| rd_err | input | 1 | Reader failure, valid while rd_busy is low |
| rd_data | input | BYTE_W | Byte returned by the reader |
| mem_we | output | 1 | Program memory write enable |
| mem_addr | output | MEM_AW | Program memory word address |
| mem_wdata | output | WORD_W | Program memory write data |
| cpu_rst | output | 1 | Processor reset, active high |
| load_err | output | 1 | Load aborted on a reader error |

## Verification
Full loads are run with three switch settings. Card bytes are a function of block and offset, and their upper two bits vary, so a wrong base block, a lost or duplicated byte, a phase slip at a block edge or leaked upper bits each give wrong words at known addresses. One load changes the switches partway through, which separates a one-time capture from live sampling. Failure at card bring-up and failure at the fourth block check that the abort is sticky. Counting requested blocks and written words shows exactly where the load stopped.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

   typedef enum logic [2:0] {
      ST_INIT,
      ST_BLK_REQ,
      ST_BLK_WAIT,
      ST_BYTE_REQ,
      ST_BYTE_WAIT,
      ST_BLK_END,
      ST_DONE,
      ST_FAIL
   } ldr_state_e;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/boot_ldr_packer.sv
module boot_ldr_packer #(
   parameter int WORD_W    = 18,
   parameter int BYTE_W    = 8,
   parameter int BPW       = 3,
   parameter int MEM_DEPTH = 1024,
   localparam int MEM_AW   = $clog2(MEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              last_word,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata
);

   localparam int GRP_W = WORD_W / BPW;
   localparam int PH_W  = (BPW > 1) ? $clog2(BPW) : 1;

   logic [PH_W-1:0]   phase_q;
   logic [MEM_AW-1:0] word_cnt_q;
   logic [GRP_W-1:0]  hold_q [BPW-1];
   logic [WORD_W-1:0] word_nx;
   logic              phase_last;

   assign phase_last = (phase_q == PH_W'(BPW - 1));
   assign last_word  = phase_last && (word_cnt_q == MEM_AW'(MEM_DEPTH - 1));

   // most significant group arrives first
   for (genvar g = 0; g < BPW - 1; g++) begin : g_slice
      assign word_nx[WORD_W-1-g*GRP_W -: GRP_W] = hold_q[g];
   end
   assign word_nx[GRP_W-1:0] = byte_in[GRP_W-1:0];

   if (BYTE_W > GRP_W) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^byte_in[BYTE_W-1:GRP_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= '0;
         word_cnt_q <= '0;
         mem_we     <= 1'b0;
         mem_addr   <= '0;
         mem_wdata  <= '0;
         for (int g = 0; g < BPW - 1; g++) hold_q[g] <= '0;
      end else begin
         mem_we <= 1'b0;
         if (byte_vld) begin
            if (phase_last) begin
               mem_we     <= 1'b1;
               mem_addr   <= word_cnt_q;
               mem_wdata  <= word_nx;
               word_cnt_q <= word_cnt_q + 1'b1;
               phase_q    <= '0;
            end else begin
               for (int g = 0; g < BPW - 1; g++)
                  if (phase_q == PH_W'(g)) hold_q[g] <= byte_in[GRP_W-1:0];
               phase_q <= phase_q + 1'b1;
            end
         end
      end
   end

   assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);
   assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(phase_q) < BPW);

endmodule

// File: rtl/boot_ldr_blkaddr.sv
module boot_ldr_blkaddr #(
   parameter int PROG_W       = 2,
   parameter int CARD_AW      = 32,
   parameter int BASE_BLOCK   = 0,
   parameter int ALIGN_BLOCKS = 8,
   parameter int BLOCKS       = 6,
   localparam int IDX_W       = (ALIGN_BLOCKS > 1) ? $clog2(ALIGN_BLOCKS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [PROG_W-1:0]  prog,
   input  logic               advance,
   output logic [CARD_AW-1:0] blk_addr
);

   logic [CARD_AW-1:0] base_nx, base_q;
   logic [IDX_W-1:0]   idx_q;

   if ((ALIGN_BLOCKS & (ALIGN_BLOCKS - 1)) == 0) begin : g_shift
      assign base_nx = CARD_AW'(BASE_BLOCK) + (CARD_AW'(prog) << $clog2(ALIGN_BLOCKS));
   end else begin : g_mult
      assign base_nx = CARD_AW'(BASE_BLOCK) + CARD_AW'(prog) * CARD_AW'(ALIGN_BLOCKS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         base_q <= base_nx;
         idx_q  <= '0;
      end else if (advance) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign blk_addr = base_q + CARD_AW'(idx_q);

   assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx_q) < BLOCKS);
   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> $stable(blk_addr));

endmodule

// File: rtl/boot_ldr.sv
module boot_ldr
   import boot_ldr_pkg::*;
#(
   parameter int PROG_W       = 2,
   parameter int WORD_W       = 18,
   parameter int BYTE_W       = 8,
   parameter int BPW          = 3,
   parameter int MEM_DEPTH    = 1024,
   parameter int BLOCK_BYTES  = 512,
   parameter int ALIGN_BLOCKS = 8,
   parameter int BASE_BLOCK   = 0,
   parameter int CARD_AW      = 32,
   localparam int MEM_AW      = $clog2(MEM_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PROG_W-1:0]  prog_sel,
   output logic               rd_block,
   output logic               rd_byte,
   output logic [CARD_AW-1:0] rd_addr,
   input  logic               rd_busy,
   input  logic               rd_err,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic               mem_we,
   output logic [MEM_AW-1:0]  mem_addr,
   output logic [WORD_W-1:0]  mem_wdata,
   output logic               cpu_rst,
   output logic               load_err
);

   localparam int OFF_W     = $clog2(BLOCK_BYTES);
   localparam int IMG_BYTES = MEM_DEPTH * BPW;
   localparam int BLOCKS    = int'(ceil_div(IMG_BYTES, BLOCK_BYTES));

   if (WORD_W % BPW != 0) begin : g_bad_split
      $error("WORD_W must divide evenly into BPW groups");
   end
   if (BYTE_W < WORD_W / BPW) begin : g_bad_byte
      $error("a byte is narrower than one word group");
   end
   if ((BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("BLOCK_BYTES must be a power of two");
   end
   if (BLOCKS > ALIGN_BLOCKS) begin : g_bad_align
      $error("image does not fit in the alignment window");
   end

   ldr_state_e       state_q, state_nx;
   logic [OFF_W-1:0] off_q;
   logic             byte_vld, last_word, load_prog, advance;

   assign load_prog = (state_q == ST_INIT) && !rd_busy && !rd_err;
   assign advance   = (state_q == ST_BLK_END);
   assign byte_vld  = (state_q == ST_BYTE_WAIT) && !rd_busy && !rd_err;

   always_comb begin
      state_nx = state_q;
      unique case (state_q)
         ST_INIT:      if (!rd_busy) state_nx = rd_err ? ST_FAIL : ST_BLK_REQ;
         ST_BLK_REQ:   state_nx = ST_BLK_WAIT;
         ST_BLK_WAIT:  if (!rd_busy) state_nx = rd_err ? ST_FAIL : ST_BYTE_REQ;
         ST_BYTE_REQ:  state_nx = ST_BYTE_WAIT;
         ST_BYTE_WAIT: begin
            if (!rd_busy) begin
               if (rd_err)                                  state_nx = ST_FAIL;
               else if (last_word)                          state_nx = ST_DONE;
               else if (off_q == OFF_W'(BLOCK_BYTES - 1))   state_nx = ST_BLK_END;
               else                                         state_nx = ST_BYTE_REQ;
            end
         end
         ST_BLK_END:   state_nx = ST_BLK_REQ;
         ST_DONE:      state_nx = ST_DONE;
         ST_FAIL:      state_nx = ST_FAIL;
         default:      state_nx = ST_FAIL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_INIT;
         off_q   <= '0;
         cpu_rst <= 1'b1;
      end else begin
         state_q <= state_nx;
         cpu_rst <= (state_q != ST_DONE);
         if (advance)       off_q <= '0;
         else if (byte_vld) off_q <= off_q + 1'b1;
      end
   end

   assign rd_block = (state_q == ST_BLK_REQ) || (state_q == ST_BLK_WAIT) ||
                     (state_q == ST_BYTE_REQ) || (state_q == ST_BYTE_WAIT);
   assign rd_byte  = (state_q == ST_BYTE_REQ);
   assign load_err = (state_q == ST_FAIL);

   boot_ldr_blkaddr #(
      .PROG_W(PROG_W), .CARD_AW(CARD_AW), .BASE_BLOCK(BASE_BLOCK),
      .ALIGN_BLOCKS(ALIGN_BLOCKS), .BLOCKS(BLOCKS)
   ) u_blkaddr (
      .clk(clk), .rst_n(rst_n), .load(load_prog), .prog(prog_sel),
      .advance(advance), .blk_addr(rd_addr)
   );

   boot_ldr_packer #(
      .WORD_W(WORD_W), .BYTE_W(BYTE_W), .BPW(BPW), .MEM_DEPTH(MEM_DEPTH)
   ) u_packer (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(rd_data),
      .last_word(last_word), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   assert_byte_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_byte |-> (rd_block && !rd_busy));
   assert_byte_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_byte |=> !rd_byte);
   assert_rst_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> cpu_rst);
   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DONE) |=> !cpu_rst);
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |=> (load_err && cpu_rst && !rd_block && !mem_we));

endmodule

// File: tb/boot_ldr_bench.sv
module boot_ldr_bench;

   localparam int INIT_CYC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  prog_sel = 2'd0;
   logic        rd_block, rd_byte, mem_we, cpu_rst, load_err;
   logic [31:0] rd_addr;
   logic [9:0]  mem_addr;
   logic [17:0] mem_wdata;

   logic        busy_m, err_m, op_byte, prev_blk, init_done_m;
   logic [7:0]  data_m;
   int          cnt_m;
   int unsigned cur_blk, ptr_m;

   int          init_fail = 0;
   int          fail_blk = -1;
   int unsigned exp_base = 0;
   int          tests = 0;
   int          fails = 0;

   int          blk_n, early_req, proto_err, wr_n, wr_bad, wr_rel;
   int unsigned blk_log [16];
   logic [17:0] cap170;

   always #10 clk = ~clk;

   boot_ldr u_boot_ldr (
      .clk(clk), .rst_n(rst_n), .prog_sel(prog_sel),
      .rd_block(rd_block), .rd_byte(rd_byte), .rd_addr(rd_addr),
      .rd_busy(busy_m), .rd_err(err_m), .rd_data(data_m),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .cpu_rst(cpu_rst), .load_err(load_err)
   );

   function automatic logic [7:0] card_byte(input int unsigned blk, input int unsigned off);
      int unsigned t;
      t = blk * 29 + off * 13 + (off >> 4) + 7;
      return t[7:0];
   endfunction

   function automatic logic [17:0] exp_word(input int unsigned base, input int unsigned w);
      logic [17:0] r;
      logic [7:0]  b;
      int unsigned g;
      r = '0;
      for (int i = 0; i < 3; i++) begin
         g = 3 * w + i;
         b = card_byte(base + g / 512, g % 512);
         r = {r[11:0], b[5:0]};
      end
      return r;
   endfunction

   // behavioural card reader
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_m <= 1'b1; err_m <= 1'b0; cnt_m <= INIT_CYC; op_byte <= 1'b0;
         prev_blk <= 1'b0; init_done_m <= 1'b0; ptr_m <= 0; cur_blk <= 0;
         data_m <= '0; blk_n <= 0; early_req <= 0;
      end else begin
         prev_blk <= rd_block;
         if (rd_block && !prev_blk) begin
            if (blk_n < 16) blk_log[blk_n] <= rd_addr;
            blk_n <= blk_n + 1;
            if (!init_done_m) early_req <= early_req + 1;
         end
         if (cnt_m != 0) begin
            cnt_m <= cnt_m - 1;
            if (cnt_m == 1) begin
               busy_m <= 1'b0;
               if (!init_done_m) begin
                  init_done_m <= 1'b1;
                  err_m <= (init_fail != 0);
               end else if (op_byte) begin
                  data_m <= card_byte(cur_blk, ptr_m);
                  ptr_m <= ptr_m + 1;
               end else begin
                  err_m <= (blk_n - 1 == fail_blk);
               end
            end
         end else if (rd_block && !prev_blk) begin
            cur_blk <= rd_addr; busy_m <= 1'b1; cnt_m <= 3; op_byte <= 1'b0; ptr_m <= 0;
         end else if (rd_byte) begin
            busy_m <= 1'b1; cnt_m <= 2; op_byte <= 1'b1;
         end
      end
   end

   // write and protocol monitor
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_n <= 0; wr_bad <= 0; wr_rel <= 0; proto_err <= 0; cap170 <= '0;
      end else begin
         if (mem_we) begin
            if (mem_addr != 10'(wr_n)) wr_bad <= wr_bad + 1;
            else if (mem_wdata != exp_word(exp_base, int'(mem_addr))) wr_bad <= wr_bad + 1;
            if (!cpu_rst) wr_rel <= wr_rel + 1;
            if (mem_addr == 10'd170) cap170 <= mem_wdata;
            wr_n <= wr_n + 1;
         end
         if (rd_byte && (busy_m || !rd_block)) proto_err <= proto_err + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic start_load(input int prog, input int f_init, input int f_blk);
      rst_n = 1'b0;
      prog_sel = 2'(prog);
      init_fail = f_init;
      fail_blk = f_blk;
      exp_base = 32'(prog) * 8;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_end();
      int n = 0;
      while (cpu_rst && !load_err && n < 40000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic check_blocks(input string tag, input int unsigned base, input int n);
      chk({tag, " block count"}, blk_n, n);
      for (int i = 0; i < n && i < 16; i++)
         chk({tag, " block number"}, int'(blk_log[i]), int'(base) + i);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 cpu_rst in reset", int'(cpu_rst), 1);
      chk("R1 rd_block in reset", int'(rd_block), 0);
      chk("R1 rd_byte in reset", int'(rd_byte), 0);
      chk("R1 mem_we in reset", int'(mem_we), 0);
      chk("R1 load_err in reset", int'(load_err), 0);
   endtask

   task automatic t_full_prog0();
      start_load(0, 0, -1);
      repeat (INIT_CYC / 2) @(negedge clk);
      chk("R2 no block during card bring-up", int'(rd_block), 0);
      wait_end();
      chk("R2 no early request", early_req, 0);
      check_blocks("R3 prog0", 0, 6);
      chk("R4 word data mismatches", wr_bad, 0);
      chk("R5 word count", wr_n, 1024);
      chk("R5 word 170 across block edge", int'(cap170), int'(exp_word(0, 170)));
      chk("R6 byte strobe protocol", proto_err, 0);
      chk("R7 writes after release", wr_rel, 0);
      chk("R7 cpu_rst released", int'(cpu_rst), 0);
      chk("R8 no error flag", int'(load_err), 0);
      repeat (20) @(negedge clk);
      chk("R5 no writes after done", wr_n, 1024);
   endtask

   task automatic t_prog2_switch();
      start_load(2, 0, -1);
      repeat (300) @(negedge clk);
      prog_sel = 2'd1;
      wait_end();
      check_blocks("R3 prog2 switch ignored", 16, 6);
      chk("R4 prog2 data mismatches", wr_bad, 0);
      chk("R5 prog2 word count", wr_n, 1024);
      chk("R7 prog2 released", int'(cpu_rst), 0);
   endtask

   task automatic t_init_err();
      start_load(1, 1, -1);
      wait_end();
      repeat (50) @(negedge clk);
      chk("R2 init error flag", int'(load_err), 1);
      chk("R2 init error no blocks", blk_n, 0);
      chk("R8 init error cpu held", int'(cpu_rst), 1);
      chk("R8 init error no writes", wr_n, 0);
   endtask

   task automatic t_read_err();
      start_load(0, 0, 3);
      wait_end();
      chk("R8 read error flag", int'(load_err), 1);
      repeat (100) @(negedge clk);
      chk("R8 flag sticky", int'(load_err), 1);
      chk("R8 cpu held", int'(cpu_rst), 1);
      chk("R8 blocks stop", blk_n, 4);
      chk("R8 writes stop", wr_n, 512);
      chk("R8 rd_block low", int'(rd_block), 0);
      chk("R4 data before error", wr_bad, 0);
   endtask

   task automatic t_prog3();
      start_load(3, 0, -1);
      wait_end();
      check_blocks("R3 prog3", 24, 6);
      chk("R4 prog3 data mismatches", wr_bad, 0);
      chk("R5 prog3 word count", wr_n, 1024);
      chk("R8 error cleared by reset", int'(load_err), 0);
      chk("R7 prog3 writes after release", wr_rel, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_full_prog0();
      t_prog2_switch();
      t_init_err();
      t_read_err();
      t_prog3();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule